// File: doc/BRIEF.md
# Unaligned Doubleword Byte Aligner

This block rebuilds a 64-bit doubleword that starts at any byte position inside a stream of naturally aligned 64-bit words. The caller fetches two consecutive aligned words and presents them together with a byte offset. The block joins the two words into a 16-byte window and returns the eight bytes that begin at the offset. Typical data is four packed 16-bit samples per word that happen to sit off a 64-bit boundary.

The offset comes from one of two places. It can be a 3-bit immediate carried with the operation, or it can be read from one of four general control registers, which software loads once before a loop with a control-write operation. A write to a control register takes two cycles to land and is never bypassed to a reader. A register-form operation that reads the register during the cycle right after the write is therefore held by a scoreboard for one cycle. A separate helper takes a byte pointer and produces, one cycle later, the aligned base address and the misalignment. Software loads the misalignment into a control register.

Top module: `byte_window_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, `res_data`, `base_out`, `mis_out` and every control register are cleared to zero. A register-form operation issued right after reset therefore uses offset 0.
- R2: An operation is accepted at a rising edge where `op_valid` is high and `op_stall` is low. At the next edge, `res_data` byte i (bits 8i+7:8i) becomes byte (offset+i) of the 16-byte value {`op_hi`,`op_lo`}. `op_lo` supplies bytes 0..7 and `op_hi` supplies bytes 8..15.
- R3: An offset of 0 returns `op_lo` unchanged.
- R4: When `op_use_imm` is 1, the offset is `op_imm`, the control registers are not read, and `op_stall` stays low.
- R5: When `op_use_imm` is 0, the offset is bits 2:0 of control register `op_sel`. All higher bits of that register have no effect on the result.
- R6: A control write is sampled at an edge where `cw_valid` is high and stores `cw_data` into register `cw_idx`. If a register-form operation reads that register in the next cycle, `op_stall` is high for exactly that one cycle. After the stall the operation completes with the newly written value.
- R7: A register-form operation that reads a register other than the one just written is not stalled.
- R8: A register-form operation issued in the same cycle as a write to its register is not stalled and uses the value the register held before that write.
- R9: One edge after `ptr_in` is sampled, `base_out` equals `ptr_in` with bits 2:0 cleared, and `mis_out` equals the low three bits of `ptr_in`, which is the pointer XOR the base.
- R10: `res_valid` is high for exactly the cycle after each accepted operation. A stalled cycle, or a cycle without `op_valid`, produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cw_valid | input | 1 | Control-register write request |
| cw_idx | input | 2 | Control register to write |
| cw_data | input | 32 | Value to write |
| op_valid | input | 1 | Align operation request |
| op_use_imm | input | 1 | 1: offset from `op_imm`; 0: offset from a control register |
| op_imm | input | 3 | Immediate byte offset |
| op_sel | input | 2 | Control register that holds the offset |
| op_lo | input | 64 | Lower aligned word of the pair |
| op_hi | input | 64 | Following aligned word |
| op_stall | output | 1 | Operation is held this cycle; keep it presented |
| res_valid | output | 1 | `res_data` holds a new result |
| res_data | output | 64 | Aligned doubleword |
| ptr_in | input | 32 | Byte pointer to split |
| base_out | output | 32 | Pointer rounded down to 8 bytes |
| mis_out | output | 3 | Byte misalignment of the pointer |

## Verification
Two functions can fall in the same cycle: a control-register write and a register-form align that reads the same register. The bench makes them collide in two ways. In the first, both are presented in one cycle, and the align must take the old offset with no stall. In the second, the align is presented one cycle after the write, and it must stall for exactly one cycle and then produce the window for the new offset. In both cases the bench judges the outcome from `op_stall` sampled before the edge and from `res_data` compared with a byte-window model built in the bench.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int DEF_DATA_W = 64;
  localparam int DEF_CTL_W  = 32;
  localparam int DEF_NUM_CTL = 4;
  localparam int DEF_PTR_W  = 32;

  typedef enum logic {
    OFS_FROM_REG = 1'b0,
    OFS_FROM_IMM = 1'b1
  } ofs_src_e;
endpackage

// File: rtl/bwa_ptr_split.sv
module bwa_ptr_split #(
  parameter int PTR_W = 32,
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] base,
  output logic [OFF_W-1:0] mis
);
  localparam logic [PTR_W-1:0] LOW_MASK = PTR_W'((1 << OFF_W) - 1);

  logic [PTR_W-1:0] base_c;
  logic [PTR_W-1:0] diff_c;

  always_comb begin
    base_c = ptr & ~LOW_MASK;
    diff_c = ptr ^ base_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      mis  <= '0;
    end else begin
      base <= base_c;
      mis  <= diff_c[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/bwa_ctl_file.sv
module bwa_ctl_file #(
  parameter int NUM_CTL = 4,
  parameter int CTL_W   = 32,
  localparam int IDX_W  = $clog2(NUM_CTL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [CTL_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [CTL_W-1:0]   rd_data,
  output logic [NUM_CTL-1:0] busy
);
  logic [CTL_W-1:0] regs [NUM_CTL];
  logic             stg_vld;
  logic [IDX_W-1:0] stg_idx;
  logic [CTL_W-1:0] stg_data;

  // first stage: capture the write; second stage: commit it to the file
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vld  <= 1'b0;
      stg_idx  <= '0;
      stg_data <= '0;
    end else begin
      stg_vld  <= wr_en;
      stg_idx  <= wr_idx;
      stg_data <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CTL; k++) regs[k] <= '0;
    end else if (stg_vld) begin
      regs[stg_idx] <= stg_data;
    end
  end

  // the file is read directly; an in-flight write is never bypassed
  assign rd_data = regs[rd_idx];

  generate
    for (genvar g = 0; g < NUM_CTL; g++) begin : g_busy
      assign busy[g] = stg_vld && (stg_idx == IDX_W'(g));
    end
  endgenerate
endmodule

// File: rtl/bwa_window.sv
module bwa_window #(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] win
);
  logic [2*DATA_W-1:0] joined;
  assign joined = {hi, lo};

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [OFF_W:0] pos;
      assign pos = {1'b0, off} + (OFF_W+1)'(i);
      assign win[i*8 +: 8] = joined[pos*8 +: 8];
    end
  endgenerate
endmodule

// File: rtl/byte_window_aligner.sv
module byte_window_aligner
  import bwa_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int CTL_W   = DEF_CTL_W,
  parameter int NUM_CTL = DEF_NUM_CTL,
  parameter int PTR_W   = DEF_PTR_W,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int IDX_W  = $clog2(NUM_CTL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_valid,
  input  logic [IDX_W-1:0]  cw_idx,
  input  logic [CTL_W-1:0]  cw_data,
  input  logic              op_valid,
  input  logic              op_use_imm,
  input  logic [OFF_W-1:0]  op_imm,
  input  logic [IDX_W-1:0]  op_sel,
  input  logic [DATA_W-1:0] op_lo,
  input  logic [DATA_W-1:0] op_hi,
  output logic              op_stall,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  input  logic [PTR_W-1:0]  ptr_in,
  output logic [PTR_W-1:0]  base_out,
  output logic [OFF_W-1:0]  mis_out
);
  ofs_src_e           src;
  logic [CTL_W-1:0]   ctl_val;
  logic [NUM_CTL-1:0] busy;
  logic [OFF_W-1:0]   off;
  logic [DATA_W-1:0]  win;
  logic               accept;

  bwa_ctl_file #(.NUM_CTL(NUM_CTL), .CTL_W(CTL_W)) u_ctl (
    .clk(clk), .rst(rst),
    .wr_en(cw_valid), .wr_idx(cw_idx), .wr_data(cw_data),
    .rd_idx(op_sel), .rd_data(ctl_val), .busy(busy)
  );

  assign src      = ofs_src_e'(op_use_imm);
  assign off      = (src == OFS_FROM_IMM) ? op_imm : ctl_val[OFF_W-1:0];
  assign op_stall = op_valid && (src == OFS_FROM_REG) && busy[op_sel];
  assign accept   = op_valid && !op_stall;

  bwa_window #(.DATA_W(DATA_W)) u_win (
    .lo(op_lo), .hi(op_hi), .off(off), .win(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= accept;
      if (accept) res_data <= win;
    end
  end

  bwa_ptr_split #(.PTR_W(PTR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst(rst), .ptr(ptr_in), .base(base_out), .mis(mis_out)
  );
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int DATA_W = 64,
  parameter int PTR_W  = 32,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cw_valid,
  input logic [IDX_W-1:0]  cw_idx,
  input logic              op_valid,
  input logic              op_use_imm,
  input logic [OFF_W-1:0]  op_imm,
  input logic [IDX_W-1:0]  op_sel,
  input logic [DATA_W-1:0] op_lo,
  input logic              op_stall,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic [PTR_W-1:0]  ptr_in,
  input logic [PTR_W-1:0]  base_out,
  input logic [OFF_W-1:0]  mis_out
);
  AST_IMM_NEVER_STALLS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_use_imm) |-> !op_stall); // R4

  AST_STALL_NEEDS_PRIOR_WRITE: assert property (@(posedge clk) disable iff (rst)
    op_stall |-> ($past(cw_valid) && ($past(cw_idx) == op_sel))); // R6

  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_stall) |=> res_valid); // R10

  AST_NO_RESULT_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && !op_stall) |=> !res_valid); // R10

  AST_ZERO_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_use_imm && (op_imm == '0)) |=> (res_data == $past(op_lo))); // R3

  AST_PTR_RECOMBINE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((base_out[OFF_W-1:0] == '0) &&
              ((base_out | PTR_W'(mis_out)) == $past(ptr_in)))); // R9
endmodule

bind byte_window_aligner bwa_checker #(
  .DATA_W(DATA_W), .PTR_W(PTR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_idx(cw_idx),
  .op_valid(op_valid), .op_use_imm(op_use_imm), .op_imm(op_imm),
  .op_sel(op_sel), .op_lo(op_lo), .op_stall(op_stall),
  .res_valid(res_valid), .res_data(res_data), .ptr_in(ptr_in),
  .base_out(base_out), .mis_out(mis_out)
);

// File: tb/sim_byte_window_aligner.sv
module sim_byte_window_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  localparam logic [63:0] V_LO [NV] = '{
    64'h0706050403020100, 64'h1122334455667788, 64'hDEADBEEFCAFEF00D,
    64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF,
    64'hA5A5A5A55A5A5A5A, 64'h8000000000000001 };
  localparam logic [63:0] V_HI [NV] = '{
    64'h0F0E0D0C0B0A0908, 64'h99AABBCCDDEEFF00, 64'h1357924680ACE0BD,
    64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 64'hFEDCBA9876543210,
    64'h3C3C3C3CC3C3C3C3, 64'h0000000180000000 };
  localparam logic [2:0]  V_OFF [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic [31:0] V_PTR [NV] = '{
    32'h00001000, 32'h00001001, 32'h0000FFFE, 32'hFFFFFFFF,
    32'h12345673, 32'h80000004, 32'h0000000D, 32'hABCDEF0A };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cw_valid = 1'b0;
  logic [1:0]  cw_idx = '0;
  logic [31:0] cw_data = '0;
  logic        op_valid = 1'b0;
  logic        op_use_imm = 1'b0;
  logic [2:0]  op_imm = '0;
  logic [1:0]  op_sel = '0;
  logic [63:0] op_lo = '0;
  logic [63:0] op_hi = '0;
  logic        op_stall;
  logic        res_valid;
  logic [63:0] res_data;
  logic [31:0] ptr_in = '0;
  logic [31:0] base_out;
  logic [2:0]  mis_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_window_aligner u0 (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_idx(cw_idx), .cw_data(cw_data),
    .op_valid(op_valid), .op_use_imm(op_use_imm), .op_imm(op_imm), .op_sel(op_sel),
    .op_lo(op_lo), .op_hi(op_hi), .op_stall(op_stall), .res_valid(res_valid),
    .res_data(res_data), .ptr_in(ptr_in), .base_out(base_out), .mis_out(mis_out)
  );

  function automatic logic [63:0] ref_win(logic [63:0] lo, logic [63:0] hi, int off);
    logic [127:0] c;
    logic [63:0] r;
    c = {hi, lo};
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = c[(off + i)*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present an operation at a falling edge, hold it while stalled, return with result visible
  task automatic run_op(input logic ui, input logic [2:0] im, input logic [1:0] sl,
                        input logic [63:0] lo, input logic [63:0] hi, output int stalls);
    @(negedge clk);
    op_valid = 1'b1; op_use_imm = ui; op_imm = im; op_sel = sl; op_lo = lo; op_hi = hi;
    stalls = 0;
    #1;
    while (op_stall) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  task automatic write_ctl(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cw_valid = 1'b1; cw_idx = idx; cw_data = d;
    @(negedge clk);
    cw_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int st;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 64'd0);
    chk(res_data == '0, "R1 res_data", res_data, 64'd0);
    chk(base_out == '0 && mis_out == '0, "R1 ptr outputs", {base_out, 29'd0, mis_out}, 64'd0);
    rst = 1'b0;
    // R1: control registers start at zero, register form gives offset 0
    run_op(1'b0, 3'd5, 2'd2, 64'h8877665544332211, 64'hFFEEDDCCBBAA9988, st);
    chk(res_valid && res_data == 64'h8877665544332211, "R1 ctl reset offset",
        res_data, 64'h8877665544332211);

    // table walk: R2/R3/R4 immediate form, R9 pointer split
    for (int v = 0; v < NV; v++) begin
      ptr_in = V_PTR[v];
      run_op(1'b1, V_OFF[v], 2'd0, V_LO[v], V_HI[v], st);
      chk(st == 0, "R4 imm no stall", 64'(st), 64'd0);
      chk(res_valid, "R10 res_valid", 64'(res_valid), 64'd1);
      chk(res_data == ref_win(V_LO[v], V_HI[v], int'(V_OFF[v])),
          (V_OFF[v] == 0) ? "R3 zero offset" : "R2 window",
          res_data, ref_win(V_LO[v], V_HI[v], int'(V_OFF[v])));
      chk(base_out == (V_PTR[v] & 32'hFFFFFFF8), "R9 base", 64'(base_out), 64'(V_PTR[v] & 32'hFFFFFFF8));
      chk(mis_out == V_PTR[v][2:0], "R9 mis", 64'(mis_out), 64'(V_PTR[v][2:0]));
    end

    // R10: no result without an operation
    @(negedge clk); #1;
    chk(res_valid == 1'b0, "R10 idle", 64'(res_valid), 64'd0);

    // R5: only low three bits of the register matter
    write_ctl(2'd3, 32'hFFFF_FFF9);
    run_op(1'b0, 3'd0, 2'd3, V_LO[1], V_HI[1], st);
    chk(res_data == ref_win(V_LO[1], V_HI[1], 1), "R5 low bits", res_data, ref_win(V_LO[1], V_HI[1], 1));
    // R4: immediate ignores a register with a nonzero offset
    run_op(1'b1, 3'd6, 2'd3, V_LO[2], V_HI[2], st);
    chk(res_data == ref_win(V_LO[2], V_HI[2], 6), "R4 ignores ctl", res_data, ref_win(V_LO[2], V_HI[2], 6));

    // R6: read in the cycle right after the write stalls exactly once
    @(negedge clk);
    cw_valid = 1'b1; cw_idx = 2'd2; cw_data = 32'd5;
    @(negedge clk);
    cw_valid = 1'b0;
    op_valid = 1'b1; op_use_imm = 1'b0; op_sel = 2'd2; op_lo = V_LO[5]; op_hi = V_HI[5];
    #1;
    chk(op_stall == 1'b1, "R6 stall first cycle", 64'(op_stall), 64'd1);
    @(negedge clk); #1;
    chk(res_valid == 1'b0, "R10 stalled no result", 64'(res_valid), 64'd0);
    chk(op_stall == 1'b0, "R6 stall one cycle", 64'(op_stall), 64'd0);
    @(negedge clk);
    op_valid = 1'b0; #1;
    chk(res_valid && res_data == ref_win(V_LO[5], V_HI[5], 5), "R6 new value",
        res_data, ref_win(V_LO[5], V_HI[5], 5));

    // R7: other register not stalled
    @(negedge clk);
    cw_valid = 1'b1; cw_idx = 2'd0; cw_data = 32'd4;
    @(negedge clk);
    cw_valid = 1'b0;
    op_valid = 1'b1; op_use_imm = 1'b0; op_sel = 2'd3; op_lo = V_LO[6]; op_hi = V_HI[6];
    #1;
    chk(op_stall == 1'b0, "R7 no stall", 64'(op_stall), 64'd0);
    @(negedge clk);
    op_valid = 1'b0; #1;
    chk(res_data == ref_win(V_LO[6], V_HI[6], 1), "R7 result", res_data, ref_win(V_LO[6], V_HI[6], 1));

    // R8: write and read in the same cycle use the old value
    write_ctl(2'd1, 32'd6);
    @(negedge clk);
    cw_valid = 1'b1; cw_idx = 2'd1; cw_data = 32'd3;
    op_valid = 1'b1; op_use_imm = 1'b0; op_sel = 2'd1; op_lo = V_LO[7]; op_hi = V_HI[7];
    #1;
    chk(op_stall == 1'b0, "R8 no stall", 64'(op_stall), 64'd0);
    @(negedge clk);
    cw_valid = 1'b0; op_valid = 1'b0; #1;
    chk(res_data == ref_win(V_LO[7], V_HI[7], 6), "R8 old value", res_data, ref_win(V_LO[7], V_HI[7], 6));
    run_op(1'b0, 3'd0, 2'd1, V_LO[7], V_HI[7], st);
    chk(res_data == ref_win(V_LO[7], V_HI[7], 3), "R8 later new value", res_data, ref_win(V_LO[7], V_HI[7], 3));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule